// File: doc/BRIEF.md
# GPIO Port Controller with Two Masked Interrupt Lines

The block is a 16-bit general-purpose I/O port with a memory-mapped register set. Software reaches it through a simple single-cycle register bus. The data register and two interrupt mask registers each sit behind four addresses. One address replaces the register. The other three apply an atomic clear, set or toggle of the bits written as 1.

Five per-bit configuration registers choose how each pin behaves. They select direction, input enable, polarity, level or edge sensing, and whether one edge or both edges count. Fifteen external pins pass through a two-flop synchronizer. For each pin that is configured as a captured input, the synchronized level is copied into the data register and tested for an interrupt condition. Each pin's condition is gated by mask A and by mask B, and drives two separate interrupt request outputs.

The controller is meant to sit next to an interrupt controller. The two request lines feed two separate interrupt sources, so software can route any pin to either line, to both, or to neither.

Top module: `pio_port`

## Requirements
- R1: After reset every register reads 0 and both `irqA` and `irqB` are low.
- R2: Registers sit at byte offsets of index*4. The offsets are:
  - 0x00 data, 0x04 data-clear, 0x08 data-set, 0x0C data-toggle
  - 0x10 maskA, 0x14/0x18/0x1C its clear/set/toggle
  - 0x20 maskB, 0x24/0x28/0x2C its clear/set/toggle
  - 0x30 direction, 0x34 polarity, 0x38 edge-select, 0x3C both-edges, 0x40 input-enable

  A write to a base or configuration address replaces the value, and configuration registers read back what was written.
- R3: A clear alias write does `reg & ~wdata`, a set alias write does `reg | wdata`, and a toggle alias write does `reg ^ wdata`.
- R4: A read of any clear/set/toggle alias returns the current value of its base register (data, maskA or maskB).
- R5: An access is an error if any of these holds:
  - `busSize` is not 1 (encoding: 0 byte, 1 halfword, 2 word, 3 reserved)
  - `busAddr[1:0]` is non-zero
  - the offset is above 0x40

  An erroneous access changes no register, pulses `busErr`, and returns `busRdata` = 0.
- R6: `busRdata` and `busErr` are registered. They hold the response in the cycle after the access and are 0 otherwise.
- R7: Data bit i follows pin i only while both direction[i] and input-enable[i] are 1. The synchronized level reaches the data register on the third rising edge after the pin changes. While a bit is captured, software writes to it have no effect. While it is not captured, the bit keeps its software value and ignores the pin.
- R8: In level mode (edge-select[i]=0), a captured pin raises its condition in every cycle that its level differs from polarity[i]. Polarity 0 means active high and polarity 1 means active low.
- R9: In single-edge mode (edge-select[i]=1, both-edges[i]=0), polarity[i]=0 reacts only to a 0-to-1 change and polarity[i]=1 reacts only to a 1-to-0 change.
- R10: In both-edges mode (edge-select[i]=1, both-edges[i]=1), any change of level is an event, whatever the value of polarity[i].
- R11: `irqA` is high in a cycle exactly when some pin had an event in the previous cycle with its maskA bit set. `irqB` works the same way with maskB. An edge gives a one-cycle pulse on the same edge that updates the data bit.
- R12: Bit 15 has no pin. It is never captured and never raises an interrupt, and it stays writable by software.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Byte offset of the access |
| busSize | input | 2 | Access size code (1 = halfword) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| busErr | output | 1 | Registered error pulse |
| pinIn | input | 15 | Asynchronous external pin levels |
| irqA | output | 1 | Interrupt request gated by mask A |
| irqB | output | 1 | Interrupt request gated by mask B |

## Verification
The assertions assume the following about the inputs:
- bus inputs are stable around the rising edge;
- `busSel` is a one-cycle request;
- pins change away from the clock edge, so the synchronizer never sees a value in flux.

The bench drives every bus field and every pin only on falling edges and holds each access for one cycle. Before any bit is put into capture, it first settles the pin levels and brings the data bits to the same levels. This way no edge is reported that the stimulus did not create.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Registers per bank: base plus clear, set and toggle aliases.
  localparam int ALIASES_PER_BANK = 4;
  localparam int NUM_BANKS        = 3;
  localparam int NUM_CFG          = 5;
  localparam int BANK_SLOTS       = NUM_BANKS * ALIASES_PER_BANK;
  localparam int NUM_REGS         = BANK_SLOTS + NUM_CFG;

  localparam logic [1:0] SIZE_HALF = 2'd1;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_TOGGLE = 2'd3
  } aliasOp_e;

  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_MASKA = 3'd1,
    SEL_MASKB = 3'd2,
    SEL_DIR   = 3'd3,
    SEL_POL   = 3'd4,
    SEL_EDGE  = 3'd5,
    SEL_BOTH  = 3'd6,
    SEL_INEN  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic     wrEn;
    logic     rdEn;
    logic     err;
    aliasOp_e op;
    regSel_e  sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output ctrlStrobe_t       strobe
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] cfgOff;
  logic             legal;
  aliasOp_e         opDec;
  regSel_e          selDec;

  assign idx    = busAddr[ADDR_W-1:2];
  assign cfgOff = idx - IDX_W'(BANK_SLOTS);
  assign legal  = (busSize == SIZE_HALF) && (busAddr[1:0] == 2'b00)
                  && (idx < IDX_W'(NUM_REGS));

  always_comb begin
    opDec  = OP_WRITE;
    selDec = SEL_DATA;
    if (idx < IDX_W'(BANK_SLOTS)) begin
      opDec  = aliasOp_e'(idx[1:0]);
      selDec = regSel_e'({1'b0, idx[3:2]});
    end else begin
      case (cfgOff)
        IDX_W'(0): selDec = SEL_DIR;
        IDX_W'(1): selDec = SEL_POL;
        IDX_W'(2): selDec = SEL_EDGE;
        IDX_W'(3): selDec = SEL_BOTH;
        default:   selDec = SEL_INEN;
      endcase
    end
  end

  always_comb begin
    strobe.wrEn = busSel & busWrite & legal;
    strobe.rdEn = busSel & ~busWrite & legal;
    strobe.err  = busSel & ~legal;
    strobe.op   = opDec;
    strobe.sel  = selDec;
  end

endmodule

// File: rtl/pio_pin_cell.sv
module pio_pin_cell (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic capEn,
  input  logic oldLvl,
  input  logic polBit,
  input  logic edgeBit,
  input  logic bothBit,
  output logic newLvl,
  output logic evt
);

  logic metaQ;
  logic stableQ;
  logic edgeHit;
  logic lvlHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ   <= 1'b0;
      stableQ <= 1'b0;
    end else begin
      metaQ   <= pinRaw;
      stableQ <= metaQ;
    end
  end

  assign newLvl = stableQ;

  always_comb begin
    if (bothBit)
      edgeHit = oldLvl ^ stableQ;
    else if (polBit)
      edgeHit = oldLvl & ~stableQ;
    else
      edgeHit = ~oldLvl & stableQ;
    lvlHit = stableQ ^ polBit;
    evt    = capEn & (edgeBit ? edgeHit : lvlHit);
  end

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_PINS = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   rdata,
  output logic                err,
  output logic                irqA,
  output logic                irqB
);

  logic [DATA_W-1:0] dataQ, maskAQ, maskBQ, dirQ, polQ, edgeQ, bothQ, inenQ;
  logic [DATA_W-1:0] dataSw, dataD, maskAD, maskBD, dirD, polD, edgeD, bothD, inenD;
  logic [DATA_W-1:0] capEn, syncLvl, evtVec;
  logic [DATA_W-1:0] rdNext, rdataQ;
  logic              errQ, irqAQ, irqBQ;

  function automatic logic [DATA_W-1:0] applyOp(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] val,
    input aliasOp_e          op
  );
    case (op)
      OP_CLEAR:  return cur & ~val;
      OP_SET:    return cur | val;
      OP_TOGGLE: return cur ^ val;
      default:   return val;
    endcase
  endfunction

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < NUM_PINS) begin : g_pin
      assign capEn[i] = dirQ[i] & inenQ[i];
      pio_pin_cell u_cell (
        .clk     (clk),
        .rstN    (rstN),
        .pinRaw  (pinIn[i]),
        .capEn   (capEn[i]),
        .oldLvl  (dataQ[i]),
        .polBit  (polQ[i]),
        .edgeBit (edgeQ[i]),
        .bothBit (bothQ[i]),
        .newLvl  (syncLvl[i]),
        .evt     (evtVec[i])
      );
    end else begin : g_nopin
      assign capEn[i]   = 1'b0;
      assign syncLvl[i] = 1'b0;
      assign evtVec[i]  = 1'b0;
    end
  end

  always_comb begin
    dataSw = dataQ;
    maskAD = maskAQ;
    maskBD = maskBQ;
    dirD   = dirQ;
    polD   = polQ;
    edgeD  = edgeQ;
    bothD  = bothQ;
    inenD  = inenQ;
    if (strobe.wrEn) begin
      case (strobe.sel)
        SEL_DATA:  dataSw = applyOp(dataQ,  wdata, strobe.op);
        SEL_MASKA: maskAD = applyOp(maskAQ, wdata, strobe.op);
        SEL_MASKB: maskBD = applyOp(maskBQ, wdata, strobe.op);
        SEL_DIR:   dirD   = wdata;
        SEL_POL:   polD   = wdata;
        SEL_EDGE:  edgeD  = wdata;
        SEL_BOTH:  bothD  = wdata;
        default:   inenD  = wdata;
      endcase
    end
    dataD = (capEn & syncLvl) | (~capEn & dataSw);
  end

  always_comb begin
    case (strobe.sel)
      SEL_DATA:  rdNext = dataQ;
      SEL_MASKA: rdNext = maskAQ;
      SEL_MASKB: rdNext = maskBQ;
      SEL_DIR:   rdNext = dirQ;
      SEL_POL:   rdNext = polQ;
      SEL_EDGE:  rdNext = edgeQ;
      SEL_BOTH:  rdNext = bothQ;
      default:   rdNext = inenQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      maskAQ <= '0;
      maskBQ <= '0;
      dirQ   <= '0;
      polQ   <= '0;
      edgeQ  <= '0;
      bothQ  <= '0;
      inenQ  <= '0;
      rdataQ <= '0;
      errQ   <= 1'b0;
      irqAQ  <= 1'b0;
      irqBQ  <= 1'b0;
    end else begin
      dataQ  <= dataD;
      maskAQ <= maskAD;
      maskBQ <= maskBD;
      dirQ   <= dirD;
      polQ   <= polD;
      edgeQ  <= edgeD;
      bothQ  <= bothD;
      inenQ  <= inenD;
      rdataQ <= strobe.rdEn ? rdNext : '0;
      errQ   <= strobe.err;
      irqAQ  <= |(evtVec & maskAQ);
      irqBQ  <= |(evtVec & maskBQ);
    end
  end

  assign rdata = rdataQ;
  assign err   = errQ;
  assign irqA  = irqAQ;
  assign irqB  = irqBQ;

  // R5: a rejected access leaves every software-owned register unchanged
  a_r5_err_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    strobe.err |=> ($stable(maskAQ) && $stable(maskBQ) && $stable(dirQ)
                    && $stable(polQ) && $stable(edgeQ) && $stable(bothQ)
                    && $stable(inenQ)));

  // R7: bits not in capture keep their value unless software writes data
  a_r7_uncaptured_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.sel == SEL_DATA)
      |=> (((dataQ ^ $past(dataQ)) & ~$past(capEn)) == '0));

  // R3: after a set-alias write every written one is present in mask A
  a_r3_set_alias: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.sel == SEL_MASKA && strobe.op == OP_SET)
      |=> ((maskAQ & $past(wdata)) == $past(wdata)));

  // R4: any read in the mask B bank returns the mask B base value
  a_r4_alias_read: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.sel == SEL_MASKB) |=> (rdata == $past(maskBQ)));

  // R11: a request line only rises for a captured pin enabled in its mask
  a_r11_irqa_masked: assert property (@(posedge clk) disable iff (!rstN)
    irqA |-> (($past(maskAQ) & $past(capEn)) != '0));

  a_r11_irqb_masked: assert property (@(posedge clk) disable iff (!rstN)
    irqB |-> (($past(maskBQ) & $past(capEn)) != '0));

endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_PINS = 15,
  parameter int ADDR_W   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [1:0]          busSize,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                busErr,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                irqA,
  output logic                irqB
);

  ctrlStrobe_t strobe;

  pio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .strobe   (strobe)
  );

  pio_datapath #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (busWdata),
    .pinIn  (pinIn),
    .rdata  (busRdata),
    .err    (busErr),
    .irqA   (irqA),
    .irqB   (irqB)
  );

endmodule

// File: tb/pio_port_tb.sv
module pio_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [1:0]  busSize = 2'd1;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busErr;
  logic [14:0] pins = '0;
  logic        irqA, irqB;

  int checks = 0;
  int fails = 0;
  int cntA = 0;
  int cntB = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_port u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .pinIn(pins),
    .irqA(irqA), .irqB(irqB)
  );

  always @(negedge clk) begin
    if (irqA) cntA++;
    if (irqB) cntB++;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [6:0] a, input logic [1:0] sz,
                        input logic [15:0] d, output logic [15:0] rd, output logic er);
    busSel = 1'b1; busWrite = wr; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    rd = busRdata; er = busErr;
  endtask

  task automatic wr16(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] rd; logic er;
    access(1'b1, a, 2'd1, d, rd, er);
  endtask

  task automatic rd16(input logic [6:0] a, output logic [15:0] v);
    logic er;
    access(1'b0, a, 2'd1, 16'h0, v, er);
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [15:0] refOp(input logic [15:0] cur, input logic [15:0] v, input int op);
    case (op)
      1: return cur & ~v;
      2: return cur | v;
      3: return cur ^ v;
      default: return v;
    endcase
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  // Transmit pin change, wait out the pipeline, return pulse counts.
  task automatic pinStep(input int p, input logic v, output int da, output int db);
    int a0, b0;
    a0 = cntA; b0 = cntB;
    pins[p] = v;
    waitCyc(6);
    da = cntA - a0; db = cntB - b0;
  endtask

  initial begin
    logic [15:0] v, mdl[3];
    logic er;
    int da, db;
    void'($urandom(32'h1234_5eed));
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd16(7'h00, v); check("R1 data", v, 16'h0);
    rd16(7'h10, v); check("R1 maskA", v, 16'h0);
    rd16(7'h40, v); check("R1 inen", v, 16'h0);
    check("R1 irq", {14'h0, irqA, irqB}, 16'h0);

    // R2 R3 R4 directed alias operations
    wr16(7'h10, 16'h00F0);
    wr16(7'h18, 16'h0F00); rd16(7'h10, v); check("R3 set", v, 16'h0FF0);
    wr16(7'h14, 16'h00F0); rd16(7'h10, v); check("R3 clear", v, 16'h0F00);
    wr16(7'h1C, 16'hFF00); rd16(7'h1C, v); check("R4 toggle alias read", v, 16'hF000);
    wr16(7'h00, 16'h1234); wr16(7'h0C, 16'h00FF);
    rd16(7'h04, v); check("R4 clear alias read", v, 16'h12CB);
    wr16(7'h34, 16'hA5A5); rd16(7'h34, v); check("R2 config readback", v, 16'hA5A5);
    wr16(7'h34, 16'h0000);

    // R5 R6 errors
    access(1'b1, 7'h10, 2'd0, 16'hFFFF, v, er); check("R5 byte write err", {15'h0, er}, 16'h1);
    rd16(7'h10, v); check("R5 byte write ignored", v, 16'hF000);
    access(1'b1, 7'h22, 2'd1, 16'hFFFF, v, er); check("R5 misaligned err", {15'h0, er}, 16'h1);
    rd16(7'h20, v); check("R5 misaligned ignored", v, 16'h0);
    access(1'b0, 7'h44, 2'd1, 16'h0, v, er); check("R5 unmapped err", {15'h0, er}, 16'h1);
    check("R5 unmapped rdata", v, 16'h0);
    access(1'b0, 7'h10, 2'd2, 16'h0, v, er); check("R5 word read err", {15'h0, er}, 16'h1);
    access(1'b0, 7'h10, 2'd1, 16'h0, v, er); check("R6 legal no err", {15'h0, er}, 16'h0);
    check("R6 rdata", v, 16'hF000);
    @(negedge clk); check("R6 rdata cleared", busRdata, 16'h0);

    // R3 R4 random alias traffic on the three banks
    rd16(7'h00, mdl[0]); rd16(7'h10, mdl[1]); rd16(7'h20, mdl[2]);
    for (int it = 0; it < 200; it++) begin
      int bank, op, rop;
      logic [15:0] val;
      bank = $urandom_range(2);
      op = $urandom_range(3);
      rop = $urandom_range(3);
      val = 16'($urandom);
      wr16(7'((bank * 4 + op) * 4), val);
      mdl[bank] = refOp(mdl[bank], val, op);
      rd16(7'((bank * 4 + rop) * 4), v);
      check("R3 R4 random alias", v, mdl[bank]);
    end

    // clean slate
    wr16(7'h00, 16'h0); wr16(7'h10, 16'h0); wr16(7'h20, 16'h0);

    // R7 capture only with dir and inen
    wr16(7'h30, 16'h0001);
    pins[0] = 1'b1; waitCyc(5);
    rd16(7'h00, v); check("R7 not captured", v, 16'h0000);
    wr16(7'h40, 16'h0001); waitCyc(5);
    rd16(7'h00, v); check("R7 captured", v, 16'h0001);
    wr16(7'h00, 16'h0000); rd16(7'h00, v); check("R7 sw write to captured ignored", v, 16'h0001);
    wr16(7'h00, 16'h8000); rd16(7'h00, v); check("R12 bit15 software", v, 16'h8001);
    pins[0] = 1'b0; waitCyc(5);
    rd16(7'h00, v); check("R7 follows pin", v, 16'h8000);

    // R8 level mode on pin 0 (level low now)
    wr16(7'h10, 16'h0001);
    da = cntA; waitCyc(5); check("R8 inactive level", 16'(cntA - da), 16'h0);
    wr16(7'h34, 16'h0001); waitCyc(2);
    check("R8 active low irqA", {15'h0, irqA}, 16'h1);
    check("R11 irqB unmasked", {15'h0, irqB}, 16'h0);
    da = cntA; waitCyc(4); check("R8 level every cycle", 16'(cntA - da), 16'h4);
    pins[0] = 1'b1; waitCyc(4);
    check("R8 released", {15'h0, irqA}, 16'h0);
    wr16(7'h34, 16'h0000); waitCyc(2);
    check("R8 active high", {15'h0, irqA}, 16'h1);
    wr16(7'h10, 16'h0000); wr16(7'h30, 16'h0); wr16(7'h40, 16'h0);
    pins[0] = 1'b0;

    // R9 R11 single edge on pin 3 with latency check
    wr16(7'h38, 16'h0008); wr16(7'h30, 16'h0008); wr16(7'h40, 16'h0008);
    waitCyc(4);
    wr16(7'h10, 16'h0008); wr16(7'h20, 16'h0008);
    pins[3] = 1'b1;
    @(negedge clk); check("R11 latency cycle1", {14'h0, irqA, irqB}, 16'h0);
    @(negedge clk); check("R11 latency cycle2", {14'h0, irqA, irqB}, 16'h0);
    @(negedge clk); check("R11 pulse both lines", {14'h0, irqA, irqB}, 16'h3);
    @(negedge clk); check("R11 pulse one cycle", {14'h0, irqA, irqB}, 16'h0);
    pinStep(3, 1'b0, da, db); check("R9 rising ignores fall", 16'(da), 16'h0);
    wr16(7'h34, 16'h0008);
    pinStep(3, 1'b1, da, db); check("R9 falling ignores rise", 16'(da), 16'h0);
    pinStep(3, 1'b0, da, db); check("R9 falling detected", 16'(da), 16'h1);

    // R10 both edges ignore polarity
    wr16(7'h3C, 16'h0008);
    pinStep(3, 1'b1, da, db); check("R10 rise counted", 16'(db), 16'h1);
    pinStep(3, 1'b0, da, db); check("R10 fall counted", 16'(db), 16'h1);
    wr16(7'h10, 16'h0); wr16(7'h20, 16'h0);
    wr16(7'h34, 16'h0); wr16(7'h3C, 16'h0);
    wr16(7'h30, 16'h0); wr16(7'h40, 16'h0); wr16(7'h38, 16'h0);

    // R12 bit 15 never captured or interrupting
    wr16(7'h04, 16'h8000);
    wr16(7'h30, 16'h8000); wr16(7'h40, 16'h8000); wr16(7'h34, 16'h8000);
    wr16(7'h10, 16'h8000);
    da = cntA; waitCyc(5); check("R12 no irq on bit15", 16'(cntA - da), 16'h0);
    wr16(7'h08, 16'h8000); rd16(7'h00, v); check("R12 bit15 writable", v & 16'h8000, 16'h8000);
    wr16(7'h10, 16'h0); wr16(7'h34, 16'h0);

    // Random edge events across pins
    pins = '0; waitCyc(4);
    wr16(7'h00, 16'h0);
    wr16(7'h38, 16'h7FFF); wr16(7'h30, 16'h7FFF); wr16(7'h40, 16'h7FFF);
    waitCyc(4);
    for (int it = 0; it < 40; it++) begin
      int p;
      logic pl, bo, ma, mb, oldv, newv, ev;
      p = $urandom_range(14);
      pl = 1'($urandom); bo = 1'($urandom); ma = 1'($urandom); mb = 1'($urandom);
      wr16(7'h34, 16'(pl) << p);
      wr16(7'h3C, 16'(bo) << p);
      wr16(7'h10, 16'(ma) << p);
      wr16(7'h20, 16'(mb) << p);
      oldv = pins[p]; newv = ~oldv;
      ev = bo ? 1'b1 : (pl ? (oldv & ~newv) : (~oldv & newv));
      pinStep(p, newv, da, db);
      check("R9 R10 R11 random irqA", 16'(da), 16'(ev & ma));
      check("R9 R10 R11 random irqB", 16'(db), 16'(ev & mb));
      rd16(7'h00, v); check("R7 random capture", 16'(v[p]), 16'(newv));
    end

    finishRun();
  end

endmodule